// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller with Nesting Status Stack

This block sits beside a small DSP-style program sequencer. It collects six maskable interrupt sources and picks one of them each time the sequencer is free to take a new one. It hands the sequencer the program-counter vector of that source over a valid/ready channel. The maskable slots are numbered 0 to 5. Their vectors are spaced four words apart, starting at 0x0004. A lower slot number, and so a lower vector, always wins. Slots 3 and 4 are each shared between a serial-port request and an external pin, and a configuration input picks which one drives the slot. Each slot is either edge-sensitive, with a pending latch, or level-sensitive, following its input directly. Software sets or clears the edge latches through a write-only set/clear port.

When the sequencer accepts a vector, the block pushes three values onto a seven-entry hardware stack: the arithmetic status and the mode status (both supplied by the sequencer) and the block's own enable mask. A return-from-interrupt strobe pops the stack. The popped mask is reloaded, and the two sequencer status words are handed back on a one-cycle restore strobe. Leaving reset, the block first offers the startup vector 0x0000. Accepting that vector does not push the stack.

Channel rules: `vec_valid` rises only when no earlier offer is still held. Once raised, it stays high, and `vec_addr` keeps its value, until a cycle in which `vec_ready` is high. That cycle is the accept cycle. The sequencer can apply back-pressure for as long as it needs, and the held offer does not change while it waits, even if higher-priority requests arrive in the meantime.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `vec_valid`=1 with `vec_addr`=0x0000, `en_mask`=0, and both error flags are 0. Accepting this startup vector pushes nothing onto the stack.
- R2: Slot i (0..5) has vector 4*(i+1). The slots are: 0 high external request, 1 serial-0 transmit, 2 serial-0 receive, 3 serial-1 transmit or external A, 4 serial-1 receive or external B, 5 timer.
- R3: A slot takes part in arbitration only if it is pending and its `en_mask` bit is 1. The lowest-numbered such slot is offered.
- R4: A new offer is loaded only when `glb_en`=1, no offer is held, and some slot takes part in arbitration. A held offer keeps `vec_valid` and `vec_addr` unchanged until `vec_ready`. `accept` is high exactly in a cycle with `vec_valid`=1 and `vec_ready`=1.
- R5: In edge mode (`edge_mode[i]`=1), a write with `sw_wr`=1 sets latch i when `sw_set[i]`=1 and clears it when `sw_clr[i]`=1. If both bits are 1, clear wins.
- R6: In level mode (`edge_mode[i]`=0), slot i is pending exactly while its input is 1, and `sw_set`/`sw_clr` have no effect on it.
- R7: In edge mode, a 0-to-1 step of the input sets the latch. Accepting that slot's vector clears the latch, unless a new edge or a set arrives in the same cycle.
- R8: `slot_sel[0]`=1 drives slot 3 from `ext_a_req` (0: from `stx1_req`). `slot_sel[1]`=1 drives slot 4 from `ext_b_req` (0: from `srx1_req`).
- R9: Each accept of a maskable vector pushes {`astat_in`, `mstat_in`, `en_mask`}. In the cycle after an `rti` pulse, `rest_valid`=1, `rest_astat`/`rest_mstat` hold the popped values, and `en_mask` holds the popped mask. A restore takes priority over a same-cycle mask write.
- R10: The stack is last-in first-out with seven entries.
- R11: A push onto a full stack is dropped and sets the sticky `ovf_err`.
- R12: A pop of an empty stack returns zeros (status words and mask) and sets the sticky `unf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for loading new offers |
| edge_mode | input | 6 | Per slot: 1 = edge-sensitive, 0 = level-sensitive |
| slot_sel | input | 2 | Source choice for shared slots 3 and 4 |
| ext_hi_req | input | 1 | External request, slot 0 |
| stx0_req | input | 1 | Serial-0 transmit request, slot 1 |
| srx0_req | input | 1 | Serial-0 receive request, slot 2 |
| stx1_req | input | 1 | Serial-1 transmit request, slot 3 |
| srx1_req | input | 1 | Serial-1 receive request, slot 4 |
| ext_a_req | input | 1 | External request A, slot 3 alternative |
| ext_b_req | input | 1 | External request B, slot 4 alternative |
| tmr_req | input | 1 | Timer request, slot 5 |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 6 | New enable mask |
| sw_wr | input | 1 | Write strobe for software set/clear |
| sw_set | input | 6 | Per-slot set bits |
| sw_clr | input | 6 | Per-slot clear bits |
| astat_in | input | AST_W | Arithmetic status to save on accept |
| mstat_in | input | MST_W | Mode status to save on accept |
| vec_valid | output | 1 | An offered vector is held |
| vec_ready | input | 1 | Sequencer takes the offered vector |
| vec_addr | output | VEC_W | Offered vector address |
| accept | output | 1 | One-cycle accept strobe |
| rti | input | 1 | Return-from-interrupt strobe, pops the stack |
| en_mask | output | 6 | Current enable mask (1 = enabled) |
| rest_valid | output | 1 | Restored status is valid this cycle |
| rest_astat | output | AST_W | Restored arithmetic status |
| rest_mstat | output | MST_W | Restored mode status |
| ovf_err | output | 1 | Sticky stack overflow flag |
| unf_err | output | 1 | Sticky stack underflow flag |

## Verification
The hardest state to reach is a full stack hit by one more nested accept, followed by the unwind that must come back out in exact reverse order. The stimulus gets there by setting the timer latch eight times through the software set port, each time with a distinct arithmetic-status value, and accepting every offer without any return. It then issues eight returns and checks seven restored values in descending order, followed by a zero restore that raises the underflow flag. The held-offer case is reached by leaving `vec_ready` low while a higher-priority slot becomes pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSLOT      = 6;
  localparam int SLOT_IW    = $clog2(NSLOT);
  localparam int VEC_STRIDE = 4;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] raw,
  input  logic [NSLOT-1:0] edge_mode,
  input  logic             sw_wr,
  input  logic [NSLOT-1:0] sw_set,
  input  logic [NSLOT-1:0] sw_clr,
  input  logic [NSLOT-1:0] take,
  output logic [NSLOT-1:0] pend
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic prev_q, lat_q, rise;
    assign rise = raw[i] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= raw[i];
        if (!edge_mode[i])                         lat_q <= 1'b0;
        else if (sw_wr && sw_clr[i])               lat_q <= 1'b0;
        else if ((sw_wr && sw_set[i]) || rise)     lat_q <= 1'b1;
        else if (take[i])                          lat_q <= 1'b0;
      end
    end

    assign pend[i] = edge_mode[i] ? lat_q : raw[i];

    // R7: an accepted edge slot with no fresh edge or set is cleared
    a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[i] && take[i] && !rise && !(sw_wr && sw_set[i])) |=> !lat_q);
    // R6: a level-mode slot never holds a latched request
    a_r6_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode[i] |=> !lat_q);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSLOT-1:0]   pend,
  input  logic [NSLOT-1:0]   mask,
  output logic [NSLOT-1:0]   gnt,
  output logic [SLOT_IW-1:0] gidx,
  output logic               any
);
  logic [NSLOT-1:0] req;
  assign req = pend & mask;
  assign any = |req;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        gidx   = SLOT_IW'(i);
      end
    end
  end

  // R3: exactly one grant when any request, none otherwise
  always_comb begin
    if (!$isunknown(req)) begin
      a_r3_one_grant: assert ($onehot0(gnt) && ((gnt != '0) == any));
    end
  end
endmodule

// File: rtl/irq_status_stack.sv
module irq_status_stack #(
  parameter int W     = 20,
  parameter int DEPTH = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         ovf,
  output logic         unf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt, cnt_mid;
  logic          pop_ok, push_ok;

  assign pop_ok   = pop && (cnt != '0);
  assign cnt_mid  = cnt - CW'(pop_ok);
  assign push_ok  = push && (cnt_mid != CW'(DEPTH));
  assign pop_data = pop_ok ? mem[cnt - CW'(1)] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      cnt <= cnt_mid + CW'(push_ok);
      if (push && !push_ok)   ovf <= 1'b1;
      if (pop && cnt == '0)   unf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[cnt_mid] <= push_data;
  end

  // R10: occupancy never exceeds the depth
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R11: push on a full stack without pop is dropped and flagged
  a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)) && ovf);
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R12: underflow flag is sticky
  a_r12_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int AST_W     = 8,
  parameter int MST_W     = 7,
  parameter int STK_DEPTH = 7,
  parameter int VEC_W     = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [NSLOT-1:0] edge_mode,
  input  logic [1:0]       slot_sel,
  input  logic             ext_hi_req,
  input  logic             stx0_req,
  input  logic             srx0_req,
  input  logic             stx1_req,
  input  logic             srx1_req,
  input  logic             ext_a_req,
  input  logic             ext_b_req,
  input  logic             tmr_req,
  input  logic             mask_wr,
  input  logic [NSLOT-1:0] mask_wdata,
  input  logic             sw_wr,
  input  logic [NSLOT-1:0] sw_set,
  input  logic [NSLOT-1:0] sw_clr,
  input  logic [AST_W-1:0] astat_in,
  input  logic [MST_W-1:0] mstat_in,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_addr,
  output logic             accept,
  input  logic             rti,
  output logic [NSLOT-1:0] en_mask,
  output logic             rest_valid,
  output logic [AST_W-1:0] rest_astat,
  output logic [MST_W-1:0] rest_mstat,
  output logic             ovf_err,
  output logic             unf_err
);
  localparam int SW = AST_W + MST_W + NSLOT;

  logic [NSLOT-1:0]   raw, pend, gnt, take;
  logic [SLOT_IW-1:0] gidx;
  logic               any, load, push;
  logic               off_boot;
  logic [NSLOT-1:0]   off_sel;
  logic [VEC_W-1:0]   vec_next;
  logic [SW-1:0]      pop_data;

  // slots 3 and 4 are shared between a serial request and an external pin
  assign raw = {tmr_req,
                slot_sel[1] ? ext_b_req : srx1_req,
                slot_sel[0] ? ext_a_req : stx1_req,
                srx0_req, stx0_req, ext_hi_req};

  irq_src_bank u_src (
    .clk, .rst_n, .raw, .edge_mode,
    .sw_wr, .sw_set, .sw_clr, .take, .pend
  );

  irq_arbiter u_arb (
    .pend, .mask(en_mask), .gnt, .gidx, .any
  );

  assign vec_next = VEC_W'((32'(gidx) + 32'd1) * VEC_STRIDE);
  assign accept   = vec_valid & vec_ready;
  assign load     = !vec_valid && glb_en && any;
  assign push     = accept && !off_boot;
  assign take     = push ? off_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b1;
      off_boot  <= 1'b1;
      vec_addr  <= '0;
      off_sel   <= '0;
    end else if (accept) begin
      vec_valid <= 1'b0;
      off_boot  <= 1'b0;
    end else if (load) begin
      vec_valid <= 1'b1;
      vec_addr  <= vec_next;
      off_sel   <= gnt;
    end
  end

  irq_status_stack #(.W(SW), .DEPTH(STK_DEPTH)) u_stk (
    .clk, .rst_n, .push,
    .push_data({astat_in, mstat_in, en_mask}),
    .pop(rti), .pop_data, .ovf(ovf_err), .unf(unf_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask    <= '0;
      rest_valid <= 1'b0;
      rest_astat <= '0;
      rest_mstat <= '0;
    end else begin
      rest_valid <= rti;
      if (rti) begin
        en_mask    <= pop_data[NSLOT-1:0];
        rest_mstat <= pop_data[NSLOT +: MST_W];
        rest_astat <= pop_data[NSLOT+MST_W +: AST_W];
      end else if (mask_wr) begin
        en_mask <= mask_wdata;
      end
    end
  end

  // R4: a held offer keeps valid and address until taken
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));
  // R4: a fresh offer needs the global enable
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(glb_en));
  // R1: the startup offer carries vector zero
  a_r1_boot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && off_boot) |-> (vec_addr == '0));
  // R9: each return yields a restore strobe next cycle
  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rti |=> rest_valid);
endmodule

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, glb_en, mask_wr, sw_wr, vec_ready, rti;
  logic [5:0] edge_mode, mask_wdata, sw_set, sw_clr;
  logic [1:0] slot_sel;
  logic       ext_hi_req, stx0_req, srx0_req, stx1_req, srx1_req;
  logic       ext_a_req, ext_b_req, tmr_req;
  logic [7:0] astat_in;
  logic [6:0] mstat_in;
  logic       vec_valid, accept, rest_valid, ovf_err, unf_err;
  logic [13:0] vec_addr;
  logic [5:0] en_mask;
  logic [7:0] rest_astat;
  logic [6:0] rest_mstat;

  irq_vec_ctrl uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_reset();
    rst_n = 0; glb_en = 0; mask_wr = 0; sw_wr = 0; vec_ready = 0; rti = 0;
    edge_mode = 6'h3F; mask_wdata = 0; sw_set = 0; sw_clr = 0; slot_sel = 0;
    ext_hi_req = 0; stx0_req = 0; srx0_req = 0; stx1_req = 0; srx1_req = 0;
    ext_a_req = 0; ext_b_req = 0; tmr_req = 0; astat_in = 0; mstat_in = 0;
    repeat (3) step();
    rst_n = 1;
    step();
  endtask

  task automatic sw_write(input logic [5:0] s, input logic [5:0] c);
    sw_wr = 1; sw_set = s; sw_clr = c; step(); sw_wr = 0; sw_set = 0; sw_clr = 0;
  endtask

  task automatic set_mask(input logic [5:0] m);
    mask_wr = 1; mask_wdata = m; step(); mask_wr = 0;
  endtask

  task automatic take_vec(input string req);
    vec_ready = 1; #1;
    chk(accept === 1'b1, req, accept, 1);
    step(); vec_ready = 0; glb_en = 0;
  endtask

  task automatic do_rti();
    rti = 1; step(); rti = 0;
  endtask

  // {set pattern, enable mask, expected vector (0 = no offer)}
  localparam logic [19:0] TBL [12] = '{
    {6'b000001, 6'h3F, 8'h04}, {6'b000010, 6'h3F, 8'h08},
    {6'b000100, 6'h3F, 8'h0C}, {6'b001000, 6'h3F, 8'h10},
    {6'b010000, 6'h3F, 8'h14}, {6'b100000, 6'h3F, 8'h18},
    {6'b111111, 6'h3F, 8'h04}, {6'b111110, 6'h3F, 8'h08},
    {6'b101000, 6'h3F, 8'h10}, {6'b111111, 6'b111100, 8'h0C},
    {6'b100001, 6'b100000, 8'h18}, {6'b010101, 6'h00, 8'h00}
  };

  initial begin
    do_reset();
    // R1 reset state
    chk(vec_valid === 1'b1 && vec_addr === 14'h0, "R1 boot offer", vec_addr, 0);
    chk(en_mask === 6'h0, "R1 mask", en_mask, 0);
    chk(ovf_err === 0 && unf_err === 0, "R1 flags", {ovf_err, unf_err}, 0);
    take_vec("R1 boot accept");
    do_rti();
    chk(rest_valid === 1 && rest_astat === 0 && unf_err === 1, "R1/R12 boot not pushed",
        {rest_valid, unf_err}, 3);

    // R2/R3 priority table
    for (int i = 0; i < 12; i++) begin
      logic [5:0] pat, msk;
      logic [7:0] exp;
      {pat, msk, exp} = TBL[i];
      sw_write(6'h0, 6'h3F);
      set_mask(msk);
      sw_write(pat, 6'h0);
      astat_in = 8'(i + 16); mstat_in = 7'(i);
      glb_en = 1;
      repeat (3) step();
      if (exp != 0) begin
        chk(vec_valid === 1 && vec_addr === 14'(exp), "R2/R3 table vector", vec_addr, exp);
        take_vec("R4 accept");
        do_rti();
        chk(rest_astat === 8'(i + 16) && rest_mstat === 7'(i), "R9 restored status",
            rest_astat, i + 16);
        chk(en_mask === msk, "R9 restored mask", en_mask, msk);
      end else begin
        chk(vec_valid === 0, "R3 masked no offer", vec_valid, 0);
        glb_en = 0;
      end
    end
    sw_write(6'h0, 6'h3F);
    set_mask(6'h3F);

    // R5 clear beats set
    sw_write(6'b000010, 6'b000010);
    glb_en = 1; repeat (3) step();
    chk(vec_valid === 0, "R5 clear wins", vec_valid, 0);
    glb_en = 0;

    // R7 edge set and auto-clear
    tmr_req = 1; step(); tmr_req = 0; step();
    glb_en = 1; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h18, "R7 edge offer", vec_addr, 14'h18);
    take_vec("R7 accept");
    glb_en = 1; repeat (3) step();
    chk(vec_valid === 0, "R7 auto-clear", vec_valid, 0);
    glb_en = 0; do_rti();

    // R6 level mode ignores software set/clear
    edge_mode = 6'b111110;
    sw_write(6'b000001, 6'h0);
    glb_en = 1; repeat (3) step();
    chk(vec_valid === 0, "R6 set ignored", vec_valid, 0);
    glb_en = 0;
    ext_hi_req = 1;
    sw_write(6'h0, 6'b000001);
    glb_en = 1; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h04, "R6 clear ignored", vec_addr, 14'h04);
    take_vec("R6 accept");
    glb_en = 1; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h04, "R6 level re-offer", vec_addr, 14'h04);
    ext_hi_req = 0;
    take_vec("R6 accept 2");
    do_rti(); do_rti();
    edge_mode = 6'h3F;

    // R4 held offer stays while a higher slot arrives
    sw_write(6'b100000, 6'h0);
    glb_en = 1; repeat (2) step();
    sw_write(6'b000001, 6'h0);
    repeat (3) step();
    chk(vec_valid === 1 && vec_addr === 14'h18, "R4 held offer", vec_addr, 14'h18);
    take_vec("R4 take held");
    glb_en = 1; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h04, "R4 next offer", vec_addr, 14'h04);
    take_vec("R4 take next");
    do_rti(); do_rti();

    // R8 shared slot selection
    slot_sel = 2'b01;
    stx1_req = 1; step(); stx1_req = 0;
    glb_en = 1; repeat (3) step();
    chk(vec_valid === 0, "R8 deselected source", vec_valid, 0);
    ext_a_req = 1; step(); ext_a_req = 0; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h10, "R8 ext A on slot 3", vec_addr, 14'h10);
    take_vec("R8 accept A");
    srx1_req = 1; step(); srx1_req = 0;
    glb_en = 1; repeat (2) step();
    chk(vec_valid === 1 && vec_addr === 14'h14, "R8 serial on slot 4", vec_addr, 14'h14);
    take_vec("R8 accept B");
    do_rti(); do_rti();

    // R10/R11/R12 nesting to overflow and unwind
    do_reset();
    take_vec("R1 boot accept 2");
    set_mask(6'h3F);
    for (int k = 1; k <= 8; k++) begin
      sw_write(6'b100000, 6'h0);
      astat_in = 8'(k);
      glb_en = 1; repeat (2) step();
      take_vec("R10 nested accept");
      if (k == 7) chk(ovf_err === 0, "R11 no overflow at seven", ovf_err, 0);
    end
    chk(ovf_err === 1, "R11 overflow flag", ovf_err, 1);
    for (int k = 7; k >= 1; k--) begin
      do_rti();
      chk(rest_astat === 8'(k), "R10 LIFO order", rest_astat, k);
    end
    chk(unf_err === 0, "R12 no underflow yet", unf_err, 0);
    do_rti();
    chk(rest_valid === 1 && rest_astat === 0 && rest_mstat === 0 && en_mask === 0 &&
        unf_err === 1, "R12 underflow zeros", rest_astat, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule